// File: doc/BRIEF.md
# Transmit Descriptor Poll Engine

This block is a bus-master transmit engine. Software builds frames in memory and describes each one with a 16-byte descriptor in a power-of-two ring. When software pulses the demand input, or when the engine has been idle for a set number of cycles, the engine looks at the descriptor at its current ring index. If software owns that entry, nothing moves. If the engine owns it, the engine fetches the buffer address, reads the frame one 32-bit word at a time, and presents it as a byte stream toward the MAC. It then hands the descriptor back to software.

Each descriptor holds four words. Byte offset 0 is the buffer address. Byte offset 4 holds a 16-bit length in its low half, stored as the negated byte count, and a 16-bit status in its high half. Status bit 15 (word bit 31) is the ownership flag, and status bit 14 (word bit 30) is the error flag. Byte offset 8 is a miscellaneous word that the engine zeroes. Byte offset 12 is unused.

The memory port takes one request at a time. A request is held until `mem_req_ready` is high. Each accepted read returns exactly one `mem_rsp_valid` beat in some later cycle. Writes need no response. The byte stream uses valid/ready: `tx_valid` stays high and `tx_data`, `tx_sof` and `tx_eof` stay unchanged until the sink raises `tx_ready`. The sink may stall for any number of cycles.

Top module: `txdesc_poll_engine`

## Requirements
- R1: After reset, `mem_req_valid` and `tx_valid` are low and the ring index is 0.
- R2: A poll first reads the word at descriptor offset 4. If bit 31 of that word is clear, the engine issues no further request and emits no byte. It leaves the descriptor unchanged and stays at the same index until the next poll.
- R3: If bit 31 is set and the length field has bit 15 set, the engine streams exactly (65536 − length) bytes from the buffer. Bytes go out little-endian within each 32-bit word. Bits 1:0 of the buffer address are ignored. The engine never drives a memory request and a stream byte in the same cycle.
- R4: `tx_sof` is high on the first byte of a frame only, and `tx_eof` is high on the last byte only.
- R5: While `tx_valid` is high and `tx_ready` is low, the byte and both markers hold their values.
- R6: On completion, the engine writes zero to offset 8 and then writes offset 4. That write carries bit 31 clear, the length unchanged, and the other status bits preserved. The status write is the last write for the descriptor.
- R7: A length with bit 15 clear, including zero, is an error. The engine streams no byte, zeroes offset 8, and writes status with bit 30 set and bit 31 clear.
- R8: After each descriptor it hands back, the engine advances its index modulo 2^`ring_log2` and polls the next entry straight away.
- R9: After `POLL_CYCLES` idle cycles with no demand, the engine polls on its own.
- R10: A memory request holds its address, write enable and data while `mem_req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_demand | input | 1 | One-cycle pulse requesting an immediate poll |
| ring_base | input | AW | Byte address of ring entry 0 (16-byte aligned) |
| ring_log2 | input | LOG_W | log2 of the number of ring entries |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Word-aligned byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Stream byte |
| tx_sof | output | 1 | First byte of frame |
| tx_eof | output | 1 | Last byte of frame |

## Verification
The assertions check the handshake rules on every cycle:
- stream and memory requests hold steady under stall;
- a stream byte and a memory request never share a cycle;
- every status write clears ownership;
- the ring index stays inside the mask;
- the idle counter stays below its limit;
- no byte is taken once the count is used up.

Only the bench scenarios can show the rest:
- byte order and frame lengths;
- the zeroing of the misc word ahead of the status write;
- skipping of frames with a bad length;
- idling on a descriptor that software owns;
- ring wrap;
- the periodic poll.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_STAT_REQ,
    S_STAT_RSP,
    S_BASE_REQ,
    S_BASE_RSP,
    S_DATA_REQ,
    S_DATA_RSP,
    S_SEND,
    S_MISC_WR,
    S_STAT_WR
  } tdp_state_e;

  localparam int OFS_STAT = 4;
  localparam int OFS_MISC = 8;
  localparam int OWN_BIT  = 31;
  localparam int ERR_BIT  = 30;
endpackage

// File: rtl/tdp_poll_timer.sv
module tdp_poll_timer #(
  parameter int POLL_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic demand,
  input  logic idle,
  output logic go
);
  localparam int CW = $clog2(POLL_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          pend;

  assign go = idle && (pend || demand || (cnt == CW'(POLL_CYCLES - 1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      pend <= (pend || demand) && !go;
      if (!idle || go) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  // R9
  poll_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(POLL_CYCLES));
endmodule

// File: rtl/tdp_ring_index.sv
module tdp_ring_index #(
  parameter int AW    = 32,
  parameter int IDX_W = 8,
  parameter int LOG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    ring_base,
  input  logic [LOG_W-1:0] ring_log2,
  input  logic             advance,
  output logic [AW-1:0]    desc_addr
);
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < IDX_W; i++) mask[i] = (LOG_W'(i) < ring_log2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       idx <= '0;
    else if (advance) idx <= (idx + 1'b1) & mask;
  end

  assign desc_addr = ring_base + (AW'(idx) << 4);

  // R8
  idx_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> ((idx & ~$past(mask)) == '0));
endmodule

// File: rtl/tdp_byte_feed.sv
module tdp_byte_feed (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_len,
  input  logic [15:0] count,
  input  logic        load_word,
  input  logic [31:0] word,
  input  logic        fire,
  output logic [7:0]  byte_out,
  output logic        first,
  output logic        last,
  output logic        lane_end
);
  logic [31:0] word_q;
  logic [1:0]  lane;
  logic [15:0] rem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      lane   <= '0;
      rem    <= '0;
      first  <= 1'b0;
    end else begin
      if (load_word) word_q <= word;
      if (load_len) begin
        rem   <= count;
        lane  <= '0;
        first <= 1'b1;
      end else if (fire) begin
        rem   <= rem - 1'b1;
        lane  <= lane + 1'b1;
        first <= 1'b0;
      end
    end
  end

  assign byte_out = word_q[8*lane +: 8];
  assign last     = (rem == 16'd1);
  assign lane_end = (lane == 2'd3);

  // R3
  no_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (rem != '0));
endmodule

// File: rtl/txdesc_poll_engine.sv
module txdesc_poll_engine
  import tdp_pkg::*;
#(
  parameter int AW          = 32,
  parameter int IDX_W       = 8,
  parameter int LOG_W       = 4,
  parameter int POLL_CYCLES = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_demand,
  input  logic [AW-1:0]    ring_base,
  input  logic [LOG_W-1:0] ring_log2,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_we,
  output logic [AW-1:0]    mem_req_addr,
  output logic [31:0]      mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_sof,
  output logic             tx_eof
);
  tdp_state_e    st;
  logic [15:0]   stat_q, len_q;
  logic          err_q;
  logic [AW-1:0] buf_ptr, desc_addr;
  logic          go, acc, fire, last, lane_end, advance;

  assign acc     = mem_req_valid && mem_req_ready;
  assign fire    = tx_valid && tx_ready;
  assign advance = (st == S_STAT_WR) && acc;

  tdp_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .demand(tx_demand),
    .idle(st == S_IDLE), .go(go)
  );

  tdp_ring_index #(.AW(AW), .IDX_W(IDX_W), .LOG_W(LOG_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_log2(ring_log2),
    .advance(advance), .desc_addr(desc_addr)
  );

  tdp_byte_feed u_feed (
    .clk(clk), .rst_n(rst_n),
    .load_len((st == S_BASE_RSP) && mem_rsp_valid),
    .count(16'h0 - len_q),
    .load_word((st == S_DATA_RSP) && mem_rsp_valid),
    .word(mem_rsp_data), .fire(fire),
    .byte_out(tx_data), .first(tx_sof), .last(last), .lane_end(lane_end)
  );

  assign tx_valid = (st == S_SEND);
  assign tx_eof   = last;

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = desc_addr;
    mem_req_wdata = '0;
    case (st)
      S_STAT_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = desc_addr + AW'(OFS_STAT);
      end
      S_BASE_REQ: mem_req_valid = 1'b1;
      S_DATA_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = buf_ptr;
      end
      S_MISC_WR: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = desc_addr + AW'(OFS_MISC);
      end
      S_STAT_WR: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = desc_addr + AW'(OFS_STAT);
        mem_req_wdata = {stat_q & 16'h7FFF, len_q};
        mem_req_wdata[ERR_BIT] = err_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      stat_q  <= '0;
      len_q   <= '0;
      err_q   <= 1'b0;
      buf_ptr <= '0;
    end else begin
      case (st)
        S_IDLE:     if (go) st <= S_STAT_REQ;
        S_STAT_REQ: if (acc) st <= S_STAT_RSP;
        S_STAT_RSP: if (mem_rsp_valid) begin
          if (!mem_rsp_data[OWN_BIT]) st <= S_IDLE;
          else begin
            stat_q <= mem_rsp_data[31:16];
            len_q  <= mem_rsp_data[15:0];
            err_q  <= !mem_rsp_data[15];
            st     <= mem_rsp_data[15] ? S_BASE_REQ : S_MISC_WR;
          end
        end
        S_BASE_REQ: if (acc) st <= S_BASE_RSP;
        S_BASE_RSP: if (mem_rsp_valid) begin
          buf_ptr <= {mem_rsp_data[AW-1:2], 2'b00};
          st      <= S_DATA_REQ;
        end
        S_DATA_REQ: if (acc) st <= S_DATA_RSP;
        S_DATA_RSP: if (mem_rsp_valid) begin
          buf_ptr <= buf_ptr + AW'(4);
          st      <= S_SEND;
        end
        S_SEND: if (fire) begin
          if (last)          st <= S_MISC_WR;
          else if (lane_end) st <= S_DATA_REQ;
        end
        S_MISC_WR: if (acc) st <= S_STAT_WR;
        S_STAT_WR: if (acc) st <= S_STAT_REQ;
        default:   st <= S_IDLE;
      endcase
    end
  end

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof));
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));
  // R6
  own_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we && (mem_req_addr[3:0] == 4'h4) |-> !mem_req_wdata[OWN_BIT]);
  // R3
  one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_valid, mem_req_valid}));
endmodule

// File: tb/txdesc_poll_engine_bench.sv
module txdesc_poll_engine_bench;
  localparam int POLL = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_demand = 1'b0;
  logic [31:0] ring_base = 32'h0;
  logic [3:0]  ring_log2 = 4'd2;
  logic        mem_req_valid, mem_req_we, mem_req_ready;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_data;
  logic        mem_rsp_valid;
  logic        tx_valid, tx_ready, tx_sof, tx_eof;
  logic [7:0]  tx_data;

  int vecs = 0, errs = 0, cyc = 0, order_bad = 0, rx_n = 0, sw_idx = 0;
  logic [31:0] mem [0:4095];
  logic        misc_seen [0:15];
  logic [7:0]  rx_b [0:8191];
  logic        rx_s [0:8191];
  logic        rx_e [0:8191];
  logic        hw_en = 1'b0;
  logic [31:0] hw_addr = '0, hw_data = '0;

  always #4 clk = ~clk;

  txdesc_poll_engine #(.POLL_CYCLES(POLL)) u_txdesc_poll_engine (
    .clk(clk), .rst_n(rst_n), .tx_demand(tx_demand), .ring_base(ring_base),
    .ring_log2(ring_log2), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof)
  );

  // memory model: sole writer of mem
  always @(posedge clk) begin
    if (hw_en) mem[hw_addr[13:2]] <= hw_data;
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      for (int i = 0; i < 16; i++) misc_seen[i] <= 1'b0;
    end else begin
      mem_req_ready <= ($urandom % 3) != 0;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          mem[mem_req_addr[13:2]] <= mem_req_wdata;
          if (mem_req_addr[3:0] == 4'h8) misc_seen[mem_req_addr[7:4]] <= 1'b1;
          if (mem_req_addr[3:0] == 4'h4) begin
            if (!misc_seen[mem_req_addr[7:4]]) order_bad <= order_bad + 1;
            misc_seen[mem_req_addr[7:4]] <= 1'b0;
          end
        end else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem[mem_req_addr[13:2]];
        end
      end
    end
  end

  // stream sink
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) tx_ready <= 1'b0;
    else begin
      tx_ready <= ($urandom % 4) != 0;
      if (tx_valid && tx_ready) begin
        rx_b[rx_n] <= tx_data;
        rx_s[rx_n] <= tx_sof;
        rx_e[rx_n] <= tx_eof;
        rx_n <= rx_n + 1;
      end
    end
  end

  function automatic logic [7:0] pat(int slot, int i);
    return 8'(slot * 37 + i * 13 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    hw_en = 1'b1; hw_addr = a; hw_data = d;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  // post descriptor di; buffer at 0x400 + di*0x100; rawlen is the length field
  task automatic post(input int di, input int len, input logic [15:0] rawlen, input bit own);
    int ba;
    ba = 32'h400 + di * 32'h100;
    for (int w = 0; w < (len + 3) / 4; w++)
      poke(ba + 4 * w, {pat(di, 4*w+3), pat(di, 4*w+2), pat(di, 4*w+1), pat(di, 4*w)});
    poke(di * 16 + 0, ba + 2);
    poke(di * 16 + 8, 32'hDEAD_BEEF);
    poke(di * 16 + 4, {(own ? 16'h8300 : 16'h0300), rawlen});
  endtask

  task automatic demand();
    @(negedge clk); tx_demand = 1'b1;
    @(negedge clk); tx_demand = 1'b0;
  endtask

  task automatic wait_clear(input int di, input string req);
    int n = 0;
    while (mem[di * 4 + 1][31] && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, req, "ownership not released", n, 0);
    repeat (40) @(negedge clk);
  endtask

  task automatic check_desc(input int di, input logic [15:0] rawlen, input bit err, input string req);
    logic [31:0] e;
    e = {(err ? 16'h4300 : 16'h0300), rawlen};
    chk(mem[di*4+1] == e, req, "status word", mem[di*4+1], e);
    chk(mem[di*4+2] == 32'h0, req, "misc word", mem[di*4+2], 0);
  endtask

  task automatic check_frame(input int di, input int len, input int off);
    int bad = 0, sofs = 0, eofs = 0;
    for (int i = 0; i < len; i++) begin
      if (rx_b[off+i] !== pat(di, i)) bad++;
      if (rx_s[off+i]) sofs++;
      if (rx_e[off+i]) eofs++;
    end
    chk(bad == 0, "R3", "byte mismatches", bad, 0);
    chk(rx_s[off] && sofs == 1, "R4", "sof count", sofs, 1);
    chk(rx_e[off+len-1] && eofs == 1, "R4", "eof count", eofs, 1);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", cyc, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
      end
    join_none
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!mem_req_valid, "R1", "mem_req_valid in reset", mem_req_valid, 0);
    chk(!tx_valid, "R1", "tx_valid in reset", tx_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req_valid && !tx_valid, "R1", "idle after reset", {mem_req_valid, tx_valid}, 0);

    // lane boundaries: 1, 4, 5 bytes
    post(0, 1, 16'(-1), 1); post(1, 4, 16'(-4), 1); post(2, 5, 16'(-5), 1);
    demand();
    wait_clear(2, "R3");
    chk(rx_n == 10, "R3", "total bytes", rx_n, 10);
    check_frame(0, 1, 0); check_frame(1, 4, 1); check_frame(2, 5, 5);
    check_desc(0, 16'(-1), 0, "R6"); check_desc(1, 16'(-4), 0, "R6"); check_desc(2, 16'(-5), 0, "R6");
    chk(order_bad == 0, "R6", "status before misc", order_bad, 0);

    // R2: entry 3 owned by software
    post(3, 10, 16'(-10), 0);
    demand();
    repeat (150) @(negedge clk);
    chk(rx_n == 10, "R2", "bytes from unowned entry", rx_n, 10);
    chk(mem[13] == {16'h0300, 16'(-10)}, "R2", "status untouched", mem[13], {16'h0300, 16'(-10)});
    chk(mem[14] == 32'hDEAD_BEEF, "R2", "misc untouched", mem[14], 32'hDEAD_BEEF);

    // R7 zero and positive lengths, R8 wrap to entry 0 then 1
    post(3, 0, 16'h0000, 1); post(0, 0, 16'h0020, 1); post(1, 60, 16'(-60), 1);
    demand();
    wait_clear(1, "R8");
    check_desc(3, 16'h0000, 1, "R7"); check_desc(0, 16'h0020, 1, "R7");
    check_desc(1, 16'(-60), 0, "R8");
    chk(rx_n == 70, "R7", "bytes after error entries", rx_n, 70);
    check_frame(1, 60, 10);
    sw_idx = 2;

    // random rounds
    for (int r = 0; r < 8; r++) begin
      int nf, base;
      int lens [3];
      int errf [3];
      int dis [3];
      logic [15:0] raws [3];
      nf = 1 + $urandom % 3;
      base = rx_n;
      for (int f = 0; f < nf; f++) begin
        dis[f] = sw_idx;
        errf[f] = ($urandom % 5) == 0;
        if (errf[f] != 0) begin
          lens[f] = 0;
          raws[f] = ($urandom % 2) ? 16'h0 : 16'(1 + $urandom % 32767);
        end else begin
          lens[f] = 1 + $urandom % 200;
          raws[f] = 16'(-lens[f]);
        end
        post(dis[f], lens[f], raws[f], 1);
        sw_idx = (sw_idx + 1) & 3;
      end
      demand();
      wait_clear(dis[nf-1], "R8");
      for (int f = 0; f < nf; f++) begin
        check_desc(dis[f], raws[f], errf[f] != 0, (errf[f] != 0) ? "R7" : "R6");
        if (errf[f] == 0) begin check_frame(dis[f], lens[f], base); base += lens[f]; end
      end
      chk(rx_n == base, "R3", "round byte total", rx_n, base);
    end
    chk(order_bad == 0, "R6", "status before misc (random)", order_bad, 0);

    // R9: no demand, periodic poll picks it up
    begin
      int base;
      base = rx_n;
      post(sw_idx, 17, 16'(-17), 1);
      repeat (POLL + 400) @(negedge clk);
      chk(!mem[sw_idx*4+1][31], "R9", "periodic poll released entry", mem[sw_idx*4+1], 0);
      chk(rx_n == base + 17, "R9", "periodic poll bytes", rx_n, base + 17);
      check_frame(sw_idx, 17, base);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule